// File: doc/BRIEF.md
# SCSI Controller Command Sequencer

This block is the command-register front end of a SCSI protocol controller. A host writes 8-bit command bytes into a command register. The block holds them in a two-slot queue and runs them one at a time. Each command occupies the engine for a fixed number of clock cycles, and the cycle in which a command retires also removes it from the queue.

Three opcodes bypass the queue. Reset Device, Reset Bus and DMA Stop discard anything that is waiting, take the head slot and start at once. The block also does the following:

- It keeps a status register and an interrupt status register, and it reports a queue overflow and an unknown opcode through them.
- It loads the transfer counter when a DMA command starts. The loaded value is 16 or 24 bits wide, as a configuration bit selects.
- It empties a 16-byte data FIFO on request.
- It acknowledges a bus reset with a one-cycle pulse. No real bus activity is modelled.

Register writes and reads share a 4-bit offset space. Read data is combinational from `rd_addr`. Read side effects take place at the clock edge where `rd_en` is high.

Top module: `scsi_cmd_seq`

## Requirements
- R1: After reset, the status register (read offset 4) and the interrupt status register (read offset 5) read 0x00. The clock factor (offset 9) reads 2, the data FIFO count (offset 7) reads 0, and `busy` is low.
- R2: A command byte (write offset 3) that arrives while the queue is empty starts on the next cycle. `busy` then stays high for exactly EXEC_CYCLES cycles. Read offset 3 returns the byte at the head of the queue.
- R3: The queue holds two commands. The second command starts the cycle after the first retires, so two back-to-back commands keep `busy` high for 2*EXEC_CYCLES cycles from the first write.
- R4: A queued-type command written while both slots are occupied is dropped and sets bit 6 (0x40) of the status register.
- R5: The opcode is in bits 6:0. Opcodes 2 (Reset Device), 3 (Reset Bus) and 4 (DMA Stop) clear the queue, become the head and restart the EXEC_CYCLES timer. They never set the overflow flag.
- R6: Accepting Reset Device sets the clock factor to 2 and the selection timeout (read offset 0xA) to 0. It also locks the command register. While the register is locked, any byte whose opcode is not 0 (NOP) is ignored. The lock clears when a NOP retires.
- R7: When a command with bit 7 set (DMA) starts, the transfer counter is loaded from the start count. The load keeps 24 bits if bit 6 of the configuration register (offset 0xC) is set, and only the low 16 bits otherwise. Commands without bit 7 leave the counter unchanged.
- R8: Read offset 0xE returns counter bits 23:16 only while configuration bit 6 is set. Otherwise it returns 0x00. Offsets 0 and 1 return bits 7:0 and 15:8.
- R9: An opcode above 4 is retired like any other command and sets bit 6 (0x40) of the interrupt status register. Any command queued behind it then runs.
- R10: When Clear FIFO (opcode 1) retires, the data FIFO count (offset 7) goes to 0 and its bottom entry (read offset 2) reads 0x00.
- R11: A read of offset 5 clears the interrupt status register and status bit 6. A read of offset 3 changes nothing.
- R12: When a Reset Bus command retires, `bus_rst_ack` goes high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write offset |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; triggers read side effects |
| rd_addr | input | 4 | Read offset |
| rd_data | output | 8 | Read data for `rd_addr` |
| busy | output | 1 | High while any queued command has not retired |
| bus_rst_ack | output | 1 | One-cycle pulse when Reset Bus retires |

## Verification
The bench fills the queue and writes a third command in the same burst. A design that queued the extra byte instead of flagging it would stay busy one command too long and leave the status register clear. A Reset Bus is written over a full queue. A design that appended it, or that let the older entries run, would show a longer busy window or a gross-error flag.

The lockout is probed with Clear FIFO and Reset Bus while locked. A design that leaked them would empty the data FIFO or pulse the acknowledge. The DMA load is tested with the 24-bit enable first clear and then set. A design that masked on read instead of on load would expose the high byte once the enable is set after a 16-bit load.

// File: rtl/scsi_cmd_seq.sv
module scsi_cmd_seq #(
  parameter int EXEC_CYCLES = 4,
  parameter int DF_DEPTH    = 16,
  parameter int CNT_W       = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic [3:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       busy,
  output logic       bus_rst_ack
);
  localparam int TW = (EXEC_CYCLES > 2) ? $clog2(EXEC_CYCLES) : 1;
  localparam int AW = $clog2(DF_DEPTH);
  localparam int PW = $clog2(DF_DEPTH + 1);

  localparam logic [6:0] OP_NOP   = 7'd0;
  localparam logic [6:0] OP_CLR   = 7'd1;
  localparam logic [6:0] OP_RDEV  = 7'd2;
  localparam logic [6:0] OP_RBUS  = 7'd3;
  localparam logic [6:0] OP_DSTOP = 7'd4;

  logic [7:0]       q0, q1, q0_n, q1_n;
  logic [1:0]       cnt, cnt_n, cnt_p;
  logic [TW-1:0]    tmr;
  logic             locked, gerr, icmd;
  logic [7:0]       clkf, selto, cfg2;
  logic [CNT_W-1:0] start_cnt, xcnt;
  logic [7:0]       dmem [DF_DEPTH];
  logic [PW-1:0]    dcnt;
  logic             start, gross;

  wire        cmd_wr    = wr_en && wr_addr == 4'h3;
  wire [6:0]  wop       = wr_data[6:0];
  wire [6:0]  hop       = q0[6:0];
  wire        done      = cnt != 2'd0 && tmr == '0;
  wire        lock_post = (done && hop == OP_NOP) ? 1'b0 : locked;
  wire        accept    = cmd_wr && !(lock_post && wop != OP_NOP);
  wire        immed     = wop == OP_RDEV || wop == OP_RBUS || wop == OP_DSTOP;
  wire        rdev_acc  = accept && wop == OP_RDEV;
  wire        rd_clr    = rd_en && rd_addr == 4'h5;
  wire        ext_en    = cfg2[6];
  wire        df_push   = wr_en && wr_addr == 4'h2 && dcnt < PW'(DF_DEPTH);

  assign busy = cnt != 2'd0;

  always_comb begin
    q0_n  = q0;
    q1_n  = q1;
    cnt_p = done ? cnt - 2'd1 : cnt;
    cnt_n = cnt_p;
    start = 1'b0;
    gross = 1'b0;
    if (done) begin
      q0_n = q1;
      if (cnt == 2'd2) start = 1'b1;
    end
    if (accept) begin
      if (immed || cnt_p == 2'd0) begin
        q0_n  = wr_data;
        cnt_n = 2'd1;
        start = 1'b1;
      end else if (cnt_p == 2'd1) begin
        q1_n  = wr_data;
        cnt_n = 2'd2;
      end else begin
        gross = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q0 <= '0;
      q1 <= '0;
      cnt <= '0;
      tmr <= '0;
      locked <= 1'b0;
      xcnt <= '0;
    end else begin
      q0 <= q0_n;
      q1 <= q1_n;
      cnt <= cnt_n;
      locked <= rdev_acc ? 1'b1 : lock_post;
      if (start) tmr <= TW'(EXEC_CYCLES - 1);
      else if (tmr != '0) tmr <= tmr - 1'b1;
      if (start && q0_n[7])
        xcnt <= ext_en ? start_cnt : {{(CNT_W-16){1'b0}}, start_cnt[15:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gerr <= 1'b0;
      icmd <= 1'b0;
      bus_rst_ack <= 1'b0;
    end else begin
      bus_rst_ack <= done && hop == OP_RBUS;
      if (gross) gerr <= 1'b1;
      else if (rd_clr) gerr <= 1'b0;
      if (done && hop > OP_DSTOP) icmd <= 1'b1;
      else if (rd_clr) icmd <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clkf <= 8'd2;
      selto <= '0;
      cfg2 <= '0;
      start_cnt <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          4'h0: start_cnt[7:0]   <= wr_data;
          4'h1: start_cnt[15:8]  <= wr_data;
          4'hE: start_cnt[23:16] <= wr_data;
          4'h5: selto <= wr_data;
          4'h9: clkf  <= wr_data;
          4'hC: cfg2  <= wr_data;
          default: ;
        endcase
      end
      if (rdev_acc) begin
        clkf  <= 8'd2;
        selto <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dcnt <= '0;
      for (int i = 0; i < DF_DEPTH; i++) dmem[i] <= '0;
    end else if (done && hop == OP_CLR) begin
      dcnt <= '0;
      dmem[0] <= '0;
    end else if (df_push) begin
      dmem[dcnt[AW-1:0]] <= wr_data;
      dcnt <= dcnt + 1'b1;
    end
  end

  always_comb begin
    case (rd_addr)
      4'h0: rd_data = xcnt[7:0];
      4'h1: rd_data = xcnt[15:8];
      4'h2: rd_data = dmem[0];
      4'h3: rd_data = q0;
      4'h4: rd_data = {1'b0, gerr, 6'b0};
      4'h5: rd_data = {1'b0, icmd, 6'b0};
      4'h7: rd_data = 8'(dcnt);
      4'h9: rd_data = clkf;
      4'hA: rd_data = selto;
      4'hC: rd_data = cfg2;
      4'hE: rd_data = ext_en ? xcnt[23:16] : 8'h00;
      default: rd_data = 8'h00;
    endcase
  end
endmodule

module scsi_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       rd_en,
  input logic [3:0] rd_addr,
  input logic [7:0] rd_data,
  input logic       busy,
  input logic [1:0] cnt,
  input logic       locked,
  input logic       done,
  input logic       gerr,
  input logic       icmd,
  input logic       cfg_ext,
  input logic       bus_rst_ack
);
  wire cmd_wr = wr_en && wr_addr == 4'h3;
  wire imm_op = wr_data[6:0] == 7'd2 || wr_data[6:0] == 7'd3 || wr_data[6:0] == 7'd4;

  // R2
  start_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && !locked) |=> busy);

  // R4
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cnt == 2'd2 && !done && !locked && !imm_op) |=> gerr);

  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && locked && !busy && wr_data[6:0] != 7'd0) |=> !busy);

  // R8
  hi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 4'hE && !cfg_ext) |-> rd_data == 8'h00);

  // R11
  int_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 4'h5 && !done) |=> !icmd);

  // R12
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_ack |=> !bus_rst_ack);
endmodule

bind scsi_cmd_seq scsi_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .cnt(cnt),
  .locked(locked), .done(done), .gerr(gerr), .icmd(icmd), .cfg_ext(cfg2[6]),
  .bus_rst_ack(bus_rst_ack)
);

// File: tb/scsi_cmd_seq_test.sv
module scsi_cmd_seq_test;
  localparam int EX = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       busy, bus_rst_ack;

  int checks = 0;
  int errors = 0;
  int acks = 0;

  always #2 clk = ~clk;

  scsi_cmd_seq #(.EXEC_CYCLES(EX)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .bus_rst_ack(bus_rst_ack)
  );

  always @(negedge clk) if (bus_rst_ack) acks++;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic run_len(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 busy", int'(busy), 0);
    rd(4'h4, v); check("R1 status", v, 8'h00);
    rd(4'h5, v); check("R1 intstat", v, 8'h00);
    rd(4'h9, v); check("R1 clkfactor", v, 8'h02);
    rd(4'h7, v); check("R1 dfifo count", v, 0);
  endtask

  task automatic t_single();
    int n;
    logic [7:0] v;
    wr(4'h3, 8'h00);
    run_len(n); check("R2 run length", n, EX);
    wr(4'h2, 8'h11); wr(4'h2, 8'h22); wr(4'h2, 8'h33);
    rd(4'h7, v); check("R10 count before clear", v, 3);
    rd(4'h2, v); check("R10 bottom before clear", v, 8'h11);
    wr(4'h3, 8'h01);
    rd(4'h3, v); check("R2 head readback", v, 8'h01);
    rd(4'h3, v); check("R11 head read no side effect", v, 8'h01);
    run_len(n); check("R11 run unaffected by reads", n, EX - 2);
    rd(4'h7, v); check("R10 count after clear", v, 0);
    rd(4'h2, v); check("R10 bottom zeroed", v, 8'h00);
  endtask

  task automatic t_queue();
    int n;
    wr(4'h3, 8'h00); wr(4'h3, 8'h00);
    run_len(n); check("R3 two queued", n, 2 * EX - 1);
  endtask

  task automatic t_overflow();
    int n;
    logic [7:0] v;
    wr(4'h3, 8'h00); wr(4'h3, 8'h00); wr(4'h3, 8'h00);
    run_len(n); check("R4 third dropped", n, 2 * EX - 2);
    rd(4'h4, v); check("R4 gross flag", v, 8'h40);
    rd(4'h5, v); check("R11 intstat read", v, 8'h00);
    rd(4'h4, v); check("R11 gross cleared by intstat read", v, 8'h00);
  endtask

  task automatic t_invalid();
    int n;
    logic [7:0] v;
    wr(4'h3, 8'h15); wr(4'h3, 8'h00);
    run_len(n); check("R9 bad op then next runs", n, 2 * EX - 1);
    rd(4'h5, v); check("R9 illegal flag", v, 8'h40);
    rd(4'h5, v); check("R11 intstat cleared", v, 8'h00);
  endtask

  task automatic t_immediate();
    int n, a0;
    logic [7:0] v;
    a0 = acks;
    wr(4'h3, 8'h00); wr(4'h3, 8'h00); wr(4'h3, 8'h03);
    run_len(n); check("R5 immediate replaces queue", n, EX);
    @(negedge clk);
    check("R12 single ack", acks - a0, 1);
    rd(4'h4, v); check("R5 no gross on immediate", v, 8'h00);
    wr(4'h3, 8'h00); wr(4'h3, 8'h00); wr(4'h3, 8'h04);
    run_len(n); check("R5 dma stop immediate", n, EX);
  endtask

  task automatic t_lock();
    int n, a0;
    logic [7:0] v;
    wr(4'h9, 8'h05); wr(4'h5, 8'h07);
    rd(4'h9, v); check("R6 clkfactor set", v, 8'h05);
    wr(4'h3, 8'h02);
    rd(4'h9, v); check("R6 clkfactor restored", v, 8'h02);
    rd(4'hA, v); check("R6 seltimeout restored", v, 8'h00);
    run_len(n);
    wr(4'h2, 8'h55);
    wr(4'h3, 8'h01);
    check("R6 locked clear ignored", int'(busy), 0);
    @(negedge clk);
    rd(4'h7, v); check("R6 dfifo untouched", v, 1);
    a0 = acks;
    wr(4'h3, 8'h03);
    check("R6 locked bus reset ignored", int'(busy), 0);
    repeat (EX + 1) @(negedge clk);
    check("R6 no ack while locked", acks - a0, 0);
    wr(4'h3, 8'h00);
    check("R6 nop accepted", int'(busy), 1);
    run_len(n);
    wr(4'h3, 8'h01);
    check("R6 unlocked accepts", int'(busy), 1);
    run_len(n);
    rd(4'h7, v); check("R10 cleared after unlock", v, 0);
  endtask

  task automatic t_dma();
    int n;
    logic [7:0] v;
    wr(4'h0, 8'hEF); wr(4'h1, 8'hCD); wr(4'hE, 8'hAB);
    wr(4'hC, 8'h00);
    wr(4'h3, 8'h80); run_len(n);
    rd(4'h0, v); check("R7 lo byte", v, 8'hEF);
    rd(4'h1, v); check("R7 mid byte", v, 8'hCD);
    rd(4'hE, v); check("R8 hi gated", v, 8'h00);
    wr(4'hC, 8'h40);
    rd(4'hE, v); check("R7 16-bit mask on load", v, 8'h00);
    wr(4'h3, 8'h80); run_len(n);
    rd(4'hE, v); check("R7 24-bit load", v, 8'hAB);
    wr(4'hC, 8'h00);
    rd(4'hE, v); check("R8 hi gated again", v, 8'h00);
    wr(4'h0, 8'h11);
    wr(4'h3, 8'h00); run_len(n);
    rd(4'h0, v); check("R7 non-dma keeps count", v, 8'hEF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_queue();
    t_overflow();
    t_invalid();
    t_immediate();
    t_lock();
    t_dma();
    repeat (2) @(negedge clk);
    report();
  end
endmodule